// File: doc/BRIEF.md
# Serial EEPROM Word Access Controller

This block is a hardware master that moves 16-bit words between a host and a serial EEPROM that speaks the common four-wire SPI command set. The host raises a one-cycle request carrying a direction, a starting word offset and a word count. The block checks the range, then drives chip select, serial clock and data out itself and samples data in. Read words come back one at a time with a valid strobe. Write words are pulled from the host with a take strobe. Every request ends with a one-cycle `done`, and `err` is raised in the same cycle when the request failed.

Before each command the controller polls the device status register until its busy bit is clear. A write is split into page-sized bursts. Each burst is preceded by a status poll and a write-enable command, and a chip-select pulse commits the burst. Words travel low byte first. For parts with 8 address bits, the ninth byte-address bit is carried inside the opcode.

States: `S_IDLE`, `S_PREP` (select low, clock low for a half period), `S_STAT_OP` and `S_STAT_IN` (status poll), `S_GAP_HI` and `S_GAP_LO` (chip-select pulse, then return to a saved state), `S_WREN`, `S_CMD`, `S_ADDR`, `S_DATA`, `S_STOP` (select high, then done).

Transitions:
- IDLE→PREP on an accepted request. A rejected request stays in IDLE and pulses done with err.
- PREP→STAT_OP→STAT_IN.
- STAT_IN→GAP when the device is ready, returning to WREN for a write or CMD for a read.
- STAT_IN→GAP when the device is busy, returning to STAT_OP.
- STAT_IN→STOP when the poll limit runs out.
- WREN→GAP, returning to CMD.
- CMD→ADDR→DATA.
- DATA→DATA for the next word.
- DATA→GAP at a page end of a write, returning to PREP.
- DATA→STOP after the last word.
- STOP→IDLE.

Top module: `ee_word_master`

## Requirements
- R1: A request is rejected, with `done` and `err` high one cycle after it and no chip-select activity, when the count is 0, when the offset is at or above DEV_WORDS, or when the count is larger than DEV_WORDS minus the offset. Offset DEV_WORDS-1 with count 1 is accepted.
- R2: Before every command, the status opcode 0x05 is sent and 8 status bits are read. Polling repeats, with a chip-select pulse between polls, until status bit 0 reads 0. After POLL_LIMIT busy polls the request ends with `err`.
- R3: The address field carries the byte address, which is the word offset times 2, in ADDR_BITS bits. With ADDR_BITS = 8 and a current offset of 128 or more, opcode bit 3 is set (read 0x0B, write 0x0A instead of 0x03 and 0x02).
- R4: Each word is byte-swapped on the wire. The device byte at address 2w is bits 7:0 of word w, and it is sent or received first.
- R5: A multi-word read issues one read command (0x03) and then streams all words back to back. Each word is presented on `rd_data` with a one-cycle `rd_valid`.
- R6: Each write burst is preceded by write enable 0x06 and a chip-select pulse, then write 0x02, the address and the data. `wr_take` pulses once per word as that word is consumed.
- R7: When the byte address after a written word is a multiple of PAGE_BYTES and words remain, the burst is closed by a chip-select pulse. A new poll, write enable and write command follow, so no burst crosses a page.
- R8: Every request produces exactly one single-cycle `done`, and `err` is high only together with `done`.
- R9: Bits are sent most significant first. Data out changes only while the clock is low, the clock is low whenever chip select is high, and data out is low when no bit is being shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | One-cycle request strobe, taken in idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | OFS_W | First word offset |
| req_count | input | OFS_W | Number of words |
| wr_data | input | 16 | Next word to write |
| wr_take | output | 1 | Current `wr_data` consumed |
| rd_data | output | 16 | Word read |
| rd_valid | output | 1 | `rd_data` valid |
| busy | output | 1 | Request in progress |
| done | output | 1 | Request finished |
| err | output | 1 | Request failed (with `done`) |
| ee_cs_n | output | 1 | Device select, active low |
| ee_sck | output | 1 | Serial clock |
| ee_mosi | output | 1 | Serial data to device |
| ee_miso | input | 1 | Serial data from device |

## Verification
The hardest paths to reach from the ports are the poll-limit exhaustion and the page break in the middle of a write. Both depend on what the device answers and where the write lands. The bench device model keeps a busy-poll counter that the stimulus preloads, either to a small value that forces a few retries or to a value past the limit. A write is started two words before a page end, so the burst must be closed and reopened while the model counts write-enable and write commands and flags any burst that crosses a page.

// File: rtl/ee_pkg.sv
package ee_pkg;

    typedef enum logic [3:0] {
        S_IDLE, S_PREP, S_STAT_OP, S_STAT_IN, S_GAP_HI, S_GAP_LO,
        S_WREN, S_CMD, S_ADDR, S_DATA, S_STOP
    } ee_state_t;

    localparam logic [7:0] OPC_READ   = 8'h03;
    localparam logic [7:0] OPC_WRITE  = 8'h02;
    localparam logic [7:0] OPC_WREN   = 8'h06;
    localparam logic [7:0] OPC_STATUS = 8'h05;
    localparam logic [7:0] OPC_HIADDR = 8'h08;

    function automatic logic [15:0] byte_swap(input logic [15:0] w);
        return {w[7:0], w[15:8]};
    endfunction

    function automatic logic is_shift(input ee_state_t s);
        return s inside {S_STAT_OP, S_STAT_IN, S_WREN, S_CMD, S_ADDR, S_DATA};
    endfunction

endpackage

// File: rtl/ee_req_check.sv
module ee_req_check #(
    parameter int DEV_WORDS = 256,
    parameter int OFS_W     = 9
) (
    input  logic [OFS_W-1:0] offset,
    input  logic [OFS_W-1:0] count,
    output logic             bad
);
    localparam logic [OFS_W:0] LIMIT = (OFS_W+1)'(DEV_WORDS);

    logic [OFS_W:0] room;

    assign room = LIMIT - {1'b0, offset};
    assign bad  = (count == '0) || ({1'b0, offset} >= LIMIT) || ({1'b0, count} > room);
endmodule

// File: rtl/ee_bit_shifter.sv
module ee_bit_shifter #(
    parameter int HALF_CYC = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [4:0]  nbits,
    input  logic [15:0] tx,
    input  logic        miso,
    output logic        sck,
    output logic        mosi,
    output logic        done,
    output logic [15:0] rx
);
    localparam int TW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [TW-1:0] T_LOAD = TW'(HALF_CYC - 1);

    logic          act, hi;
    logic [TW-1:0] tmr;
    logic [4:0]    left;
    logic [15:0]   sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act  <= 1'b0;
            hi   <= 1'b0;
            tmr  <= '0;
            left <= '0;
            sr   <= '0;
            rx   <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!act) begin
                if (start) begin
                    act  <= 1'b1;
                    hi   <= 1'b0;
                    tmr  <= T_LOAD;
                    left <= nbits;
                    sr   <= tx << (5'd16 - nbits);
                end
            end else if (tmr != '0) begin
                tmr <= tmr - 1'b1;
            end else if (!hi) begin
                hi  <= 1'b1;
                tmr <= T_LOAD;
            end else begin
                hi   <= 1'b0;
                tmr  <= T_LOAD;
                rx   <= {rx[14:0], miso};
                sr   <= {sr[14:0], 1'b0};
                left <= left - 1'b1;
                if (left == 5'd1) begin
                    act  <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign sck  = act & hi;
    assign mosi = act & sr[15];
endmodule

// File: rtl/ee_word_master.sv
module ee_word_master
    import ee_pkg::*;
#(
    parameter int DEV_WORDS  = 256,
    parameter int ADDR_BITS  = 8,
    parameter int OP_BITS    = 8,
    parameter int PAGE_BYTES = 8,
    parameter int HALF_CYC   = 2,
    parameter int POLL_LIMIT = 6,
    parameter int OFS_W      = $clog2(DEV_WORDS) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [OFS_W-1:0] req_offset,
    input  logic [OFS_W-1:0] req_count,
    input  logic [15:0]      wr_data,
    output logic             wr_take,
    output logic [15:0]      rd_data,
    output logic             rd_valid,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic             ee_cs_n,
    output logic             ee_sck,
    output logic             ee_mosi,
    input  logic             ee_miso
);
    localparam int TW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam int RW = $clog2(POLL_LIMIT + 1);
    localparam logic [TW-1:0]  T_LOAD  = TW'(HALF_CYC - 1);
    localparam logic [RW-1:0]  R_LAST  = RW'(POLL_LIMIT - 1);
    localparam logic [OFS_W:0] PG_MASK = (OFS_W+1)'(PAGE_BYTES - 1);
    localparam logic [4:0]     OP_NB   = 5'(OP_BITS);
    localparam logic [4:0]     AD_NB   = 5'(ADDR_BITS);

    ee_state_t        st, st_nx, ret_st, ret_nx;
    logic [TW-1:0]    tmr;
    logic [OFS_W-1:0] cur_off, left, nxt_off;
    logic [OFS_W:0]   byte_addr;
    logic [RW-1:0]    retry;
    logic             is_wr, fail, kick;
    logic             req_bad, sh_done, tmr_zero, page_end, hi_addr;
    logic [15:0]      sh_rx, sh_tx;
    logic [4:0]       sh_nb;

    ee_req_check #(.DEV_WORDS(DEV_WORDS), .OFS_W(OFS_W)) u_range (
        .offset(req_offset), .count(req_count), .bad(req_bad)
    );

    ee_bit_shifter #(.HALF_CYC(HALF_CYC)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(kick), .nbits(sh_nb), .tx(sh_tx),
        .miso(ee_miso), .sck(ee_sck), .mosi(ee_mosi), .done(sh_done), .rx(sh_rx)
    );

    assign tmr_zero  = (tmr == '0);
    assign nxt_off   = cur_off + 1'b1;
    assign byte_addr = {cur_off, 1'b0};
    assign page_end  = (({nxt_off, 1'b0}) & PG_MASK) == '0;
    assign hi_addr   = (ADDR_BITS == 8) && (cur_off >= OFS_W'(128));

    // next state
    always_comb begin
        st_nx  = st;
        ret_nx = ret_st;
        unique case (st)
            S_IDLE:    if (req_valid && !req_bad) st_nx = S_PREP;
            S_PREP:    if (tmr_zero) st_nx = S_STAT_OP;
            S_STAT_OP: if (sh_done) st_nx = S_STAT_IN;
            S_STAT_IN: if (sh_done) begin
                if (!sh_rx[0]) begin
                    st_nx  = S_GAP_HI;
                    ret_nx = is_wr ? S_WREN : S_CMD;
                end else if (retry == R_LAST) begin
                    st_nx = S_STOP;
                end else begin
                    st_nx  = S_GAP_HI;
                    ret_nx = S_STAT_OP;
                end
            end
            S_GAP_HI:  if (tmr_zero) st_nx = S_GAP_LO;
            S_GAP_LO:  if (tmr_zero) st_nx = ret_st;
            S_WREN:    if (sh_done) begin
                st_nx  = S_GAP_HI;
                ret_nx = S_CMD;
            end
            S_CMD:     if (sh_done) st_nx = S_ADDR;
            S_ADDR:    if (sh_done) st_nx = S_DATA;
            S_DATA:    if (sh_done) begin
                if (left == OFS_W'(1)) begin
                    st_nx = S_STOP;
                end else if (is_wr && page_end) begin
                    st_nx  = S_GAP_HI;
                    ret_nx = S_PREP;
                end
            end
            S_STOP:    if (tmr_zero) st_nx = S_IDLE;
            default:   st_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= S_IDLE;
            ret_st <= S_IDLE;
            kick   <= 1'b0;
        end else begin
            st     <= st_nx;
            ret_st <= ret_nx;
            kick   <= is_shift(st_nx) && ((st_nx != st) || sh_done);
        end
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr      <= '0;
            cur_off  <= '0;
            left     <= '0;
            retry    <= '0;
            is_wr    <= 1'b0;
            fail     <= 1'b0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
            done     <= 1'b0;
            err      <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            done     <= 1'b0;
            err      <= 1'b0;
            if (st_nx != st) tmr <= T_LOAD;
            else if (!tmr_zero) tmr <= tmr - 1'b1;
            unique case (st)
                S_IDLE: if (req_valid) begin
                    if (req_bad) begin
                        done <= 1'b1;
                        err  <= 1'b1;
                    end else begin
                        is_wr   <= req_write;
                        cur_off <= req_offset;
                        left    <= req_count;
                        retry   <= '0;
                        fail    <= 1'b0;
                    end
                end
                S_STAT_IN: if (sh_done) begin
                    if (sh_rx[0]) begin
                        retry <= retry + 1'b1;
                        if (retry == R_LAST) fail <= 1'b1;
                    end else begin
                        retry <= '0;
                    end
                end
                S_DATA: if (sh_done) begin
                    cur_off <= nxt_off;
                    left    <= left - 1'b1;
                    if (!is_wr) begin
                        rd_valid <= 1'b1;
                        rd_data  <= byte_swap(sh_rx);
                    end
                end
                S_STOP: if (tmr_zero) begin
                    done <= 1'b1;
                    err  <= fail;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        ee_cs_n = 1'b0;
        sh_tx   = '0;
        sh_nb   = 5'd8;
        unique case (st)
            S_IDLE, S_GAP_HI, S_STOP: ee_cs_n = 1'b1;
            S_STAT_OP: begin
                sh_tx = {8'h00, OPC_STATUS};
                sh_nb = OP_NB;
            end
            S_WREN: begin
                sh_tx = {8'h00, OPC_WREN};
                sh_nb = OP_NB;
            end
            S_CMD: begin
                sh_tx = {8'h00, (is_wr ? OPC_WRITE : OPC_READ) | (hi_addr ? OPC_HIADDR : 8'h00)};
                sh_nb = OP_NB;
            end
            S_ADDR: begin
                sh_tx = 16'(byte_addr);
                sh_nb = AD_NB;
            end
            S_DATA: begin
                sh_tx = is_wr ? byte_swap(wr_data) : 16'h0000;
                sh_nb = 5'd16;
            end
            default: ;
        endcase
    end

    assign busy    = (st != S_IDLE);
    assign wr_take = kick && (st == S_DATA) && is_wr;
endmodule

// File: rtl/ee_word_master_chk.sv
module ee_word_master_chk #(
    parameter int DEV_WORDS = 256,
    parameter int OFS_W     = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [OFS_W-1:0] req_offset,
    input logic [OFS_W-1:0] req_count,
    input logic             busy,
    input logic             done,
    input logic             err,
    input logic             rd_valid,
    input logic             wr_take,
    input logic             ee_cs_n,
    input logic             ee_sck,
    input logic             ee_mosi
);
    // R9
    idle_clock_chk: assert property (@(posedge clk) disable iff (!rst_n) ee_cs_n |-> !ee_sck);
    // R9
    mosi_steady_chk: assert property (@(posedge clk) disable iff (!rst_n) !$stable(ee_mosi) |-> !ee_sck);
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
    // R8
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n) err |-> done);
    // R1
    reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && (req_count == '0 || int'(req_offset) >= DEV_WORDS ||
         int'(req_count) > DEV_WORDS - int'(req_offset))) |=> (done && err && ee_cs_n));
    // R5
    rdv_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_valid |-> busy);
    // R6
    take_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) wr_take |-> (busy && !ee_cs_n));
endmodule

bind ee_word_master ee_word_master_chk #(.DEV_WORDS(DEV_WORDS), .OFS_W(OFS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_offset(req_offset),
    .req_count(req_count), .busy(busy), .done(done), .err(err), .rd_valid(rd_valid),
    .wr_take(wr_take), .ee_cs_n(ee_cs_n), .ee_sck(ee_sck), .ee_mosi(ee_mosi)
);

// File: tb/test_ee_word_master.sv
module test_ee_word_master;
    localparam int DW = 256, OW = 9, PB = 8, PL = 6;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 0, req_write = 0;
    logic [OW-1:0] req_offset = '0, req_count = '0;
    logic [15:0] wr_data, rd_data;
    logic wr_take, rd_valid, busy, done, err, ee_cs_n, ee_sck, ee_mosi;
    logic ee_miso = 1'b0;

    always #5 clk = ~clk;

    ee_word_master i_ee_word_master (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_offset(req_offset), .req_count(req_count), .wr_data(wr_data), .wr_take(wr_take),
        .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy), .done(done), .err(err),
        .ee_cs_n(ee_cs_n), .ee_sck(ee_sck), .ee_mosi(ee_mosi), .ee_miso(ee_miso)
    );

    int checks = 0, fails = 0;
    bit finished = 0;

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural serial EEPROM ----------------
    logic [7:0] dev [0:511];
    logic [7:0] pend [0:63];
    int npend, bitn, busy_polls = 0;
    int n_rd = 0, n_wr = 0, n_wren = 0, n_stat = 0, cs_falls = 0;
    logic [7:0] sh = 0, op = 0, last_op = 0;
    logic [8:0] baddr = 0;
    bit wel = 0, cross_err = 0, p_cs = 1, p_sck = 0;

    always @(ee_cs_n or ee_sck) begin
        if (ee_cs_n !== p_cs) begin
            if (!ee_cs_n) begin
                bitn = 0; npend = 0; op = 0; ee_miso = 0; cs_falls++;
            end else begin
                if (op == 8'h06 && bitn >= 8) wel = 1;
                if ((op & 8'hF7) == 8'h02 && npend > 0 && wel) begin
                    if ((int'(baddr) / PB) != ((int'(baddr) + npend - 1) / PB)) cross_err = 1;
                    for (int i = 0; i < npend; i++) dev[(int'(baddr) + i) % 512] = pend[i];
                    wel = 0;
                    busy_polls = 2;
                end
            end
        end
        if (ee_sck !== p_sck && !ee_cs_n) begin
            if (ee_sck) begin
                sh = {sh[6:0], ee_mosi};
                bitn++;
                if (bitn == 8) begin
                    op = sh;
                    if ((op & 8'hF7) == 8'h03) begin n_rd++; last_op = op; end
                    if ((op & 8'hF7) == 8'h02) begin n_wr++; last_op = op; end
                    if (op == 8'h06) n_wren++;
                    if (op == 8'h05) n_stat++;
                end
                if (bitn == 16 && ((op & 8'hF7) == 8'h03 || (op & 8'hF7) == 8'h02)) baddr = {op[3], sh};
                if (bitn > 16 && bitn % 8 == 0 && (op & 8'hF7) == 8'h02 && npend < 64) begin
                    pend[npend] = sh; npend++;
                end
            end else begin
                if (op == 8'h05 && bitn >= 8 && bitn < 16)
                    ee_miso = (bitn == 15) ? (busy_polls > 0) : 1'b0;
                if (op == 8'h05 && bitn == 16 && busy_polls > 0) busy_polls--;
                if ((op & 8'hF7) == 8'h03 && bitn >= 16) begin
                    automatic int k = bitn - 16;
                    automatic logic [7:0] b = dev[(int'(baddr) + k / 8) % 512];
                    ee_miso = b[7 - k % 8];
                end
            end
        end
        p_cs = ee_cs_n; p_sck = ee_sck;
    end

    function automatic logic [15:0] word_at(input int w);
        return {dev[2*w+1], dev[2*w]};
    endfunction

    // ---------------- write data source ----------------
    logic [15:0] wbuf [0:15];
    int n_take = 0, base = 0;
    always @(posedge clk) if (wr_take) n_take <= n_take + 1;
    assign wr_data = wbuf[(n_take - base) & 15];

    // ---------------- per-clock pin rules (R9) ----------------
    always @(negedge clk) if (rst_n && !finished) begin
        chk("R9 idle pins", {ee_cs_n & (ee_sck | ee_mosi)}, 0);
    end

    // ---------------- request runner ----------------
    logic [15:0] rd_q [$];
    int n_done, got_err;
    task automatic run(input bit wr, input int off, input int cnt);
        int guard;
        rd_q.delete(); n_done = 0; got_err = 0; base = n_take;
        @(negedge clk);
        req_valid = 1; req_write = wr; req_offset = OW'(off); req_count = OW'(cnt);
        guard = 0;
        do begin
            @(negedge clk);
            req_valid = 0;
            if (rd_valid) rd_q.push_back(rd_data);
            if (done) begin n_done++; got_err = err; end
            guard++;
        end while (n_done == 0 && guard < 20000);
        repeat (4) begin
            @(negedge clk);
            if (done) n_done++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            fails++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int f0, r0, w0, e0, s0, t0;
        for (int i = 0; i < 512; i++) dev[i] = 8'(i * 7 + 3) ^ 8'(i >> 3);
        for (int i = 0; i < 16; i++) wbuf[i] = 16'h0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R8 reset busy/done/err", {busy, done, err}, 0);
        chk("R9 reset cs/sck", {ee_cs_n, ee_sck}, 2'b10);

        // R1 rejections
        f0 = cs_falls;
        run(0, 256, 1);
        chk("R1 offset beyond", got_err, 1);
        chk("R8 one done", n_done, 1);
        run(0, 10, 0);
        chk("R1 zero count", got_err, 1);
        run(1, 250, 7);
        chk("R1 count too large", got_err, 1);
        chk("R1 no bus activity", cs_falls, f0);

        // R1 edge accept, R4 swap
        run(0, 255, 1);
        chk("R1 last word accepted", got_err, 0);
        chk("R4 last word data", rd_q.size() > 0 ? rd_q[0] : 16'hDEAD, word_at(255));

        // R5 multi-word read
        r0 = n_rd;
        run(0, 10, 4);
        chk("R5 one read cmd", n_rd - r0, 1);
        chk("R5 word count", rd_q.size(), 4);
        for (int i = 0; i < 4; i++)
            chk($sformatf("R5 R4 word %0d", i), rd_q.size() > i ? rd_q[i] : 16'hDEAD, word_at(10 + i));
        chk("R8 read one done", n_done, 1);

        // R3 high address read
        run(0, 130, 2);
        chk("R3 read opcode", last_op, 8'h0B);
        chk("R3 high read w0", rd_q.size() > 0 ? rd_q[0] : 16'hDEAD, word_at(130));
        chk("R3 high read w1", rd_q.size() > 1 ? rd_q[1] : 16'hDEAD, word_at(131));
        run(0, 20, 1);
        chk("R3 low read opcode", last_op, 8'h03);
        chk("R3 low read data", rd_q.size() > 0 ? rd_q[0] : 16'hDEAD, word_at(20));

        // R2 retry polls
        busy_polls = 3; s0 = n_stat;
        run(0, 40, 1);
        chk("R2 poll count", n_stat - s0, 4);
        chk("R2 no error", got_err, 0);
        chk("R2 data after poll", rd_q.size() > 0 ? rd_q[0] : 16'hDEAD, word_at(40));

        // R2 timeout
        busy_polls = 100; s0 = n_stat; r0 = n_rd;
        run(0, 40, 1);
        chk("R2 timeout err", got_err, 1);
        chk("R2 timeout polls", n_stat - s0, PL);
        chk("R2 no read cmd", n_rd - r0, 0);
        chk("R8 timeout one done", n_done, 1);
        busy_polls = 0;

        // R6 R7 write across a page
        for (int i = 0; i < 6; i++) wbuf[i] = 16'hA100 + 16'(i * 16'h0111);
        w0 = n_wr; e0 = n_wren; t0 = n_take; cross_err = 0;
        run(1, 2, 6);
        chk("R6 write no error", got_err, 0);
        chk("R7 two bursts", n_wr - w0, 2);
        chk("R6 wren per burst", n_wren - e0, 2);
        chk("R7 no page crossing", cross_err, 0);
        chk("R6 take count", n_take - t0, 6);
        chk("R3 write opcode", last_op, 8'h02);
        for (int i = 0; i < 6; i++) begin
            chk($sformatf("R4 low byte %0d", i), dev[2*(2+i)], wbuf[i][7:0]);
            chk($sformatf("R4 high byte %0d", i), dev[2*(2+i)+1], wbuf[i][15:8]);
        end
        run(0, 2, 6);
        for (int i = 0; i < 6; i++)
            chk($sformatf("R6 readback %0d", i), rd_q.size() > i ? rd_q[i] : 16'hDEAD, wbuf[i]);

        // R3 high write
        wbuf[0] = 16'h1234; wbuf[1] = 16'hBEEF; w0 = n_wr;
        run(1, 200, 2);
        chk("R3 high write opcode", last_op, 8'h0A);
        chk("R7 single burst", n_wr - w0, 1);
        chk("R3 high write w0", word_at(200), 16'h1234);
        chk("R3 high write w1", word_at(201), 16'hBEEF);

        // R7 single word ending exactly at page end
        wbuf[0] = 16'h5A5A; w0 = n_wr; cross_err = 0;
        run(1, 3, 1);
        chk("R7 one word one burst", n_wr - w0, 1);
        chk("R7 one word data", word_at(3), 16'h5A5A);
        chk("R7 no crossing", cross_err, 0);

        repeat (5) @(negedge clk);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule